// File: doc/BRIEF.md
# AEGIS-128 State Update Unit

This block keeps the 640-bit working state of the AEGIS-128 authenticated cipher as five 128-bit words and advances it by one step in a single clock cycle. A step sends each word through one unkeyed AES round and XORs the result with the next word, which acts as the round key. The word at position 0 also takes in a 128-bit message word. All five rounds are computed in parallel from the old state, so steps can run back to back on every cycle.

A surrounding controller seeds the state through a parallel load port. It then issues steps, either with message words to absorb or with an all-zero message when nothing is to be injected. On every cycle the block also presents a keystream word formed from the current state, which the controller uses to encrypt or decrypt data.

Top module: `aegis_step_unit`

## Requirements
- R1: A synchronous active-high reset sets all five state words to zero, and the keystream output then reads zero.
- R2: When `loadEn` is high, all five words are written from `loadState` in one cycle. Word i occupies bits [128*i+127 : 128*i] of both `loadState` and `stateOut`.
- R3: If `loadEn` and `stepEn` are high in the same cycle, the load wins and the step has no effect on the state.
- R4: With neither strobe high, the state holds, and any value on `msgWord` is ignored.
- R5: On a step, for i from 1 to 4, new word i equals the AES round of old word i-1 XOR old word i.
- R6: On a step, new word 0 equals the AES round of old word 4 XOR old word 0 XOR `msgWord`.
- R7: `keyStream` always equals word1 XOR word4 XOR (word2 AND word3) of the current state.
- R8: The AES round is SubBytes, then ShiftRows, then MixColumns, and it has no final-round variant. Byte k of a word is bits [8k+7:8k] and sits in column k/4 and row k%4. Because of this, a step from the all-zero state with a zero message gives 0x63 in every byte of every word.
- R9: Steps issued on consecutive cycles each complete in one cycle, with the result visible on `stateOut` after the clock edge that applied the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loadEn | input | 1 | Write all five words from `loadState` |
| loadState | input | 640 | Parallel load value, word i at bits 128*i upward |
| stepEn | input | 1 | Advance the state by one step |
| msgWord | input | 128 | Message word absorbed into word 0 on a step |
| stateOut | output | 640 | Current state, word i at bits 128*i upward |
| keyStream | output | 128 | word1 ^ word4 ^ (word2 & word3) |

## Verification
The bench targets the direction of the chain. A design that fed each round from the wrong neighbour, or that swapped the round input with the key, would produce words that differ from the reference after the first step. A load and a step in the same cycle tests the priority rule: a design that let the step win would leave a stepped state where the loaded state should be. The all-zero known answer exposes a wrong S-box, ShiftRows direction or MixColumns. Idle cycles with a nonzero message show whether the message leaks into the state when no step is requested. Back-to-back steps with varied messages show whether a step is lost or a stale word is reused.

// File: rtl/aegis_step_pkg.sv
package aegis_step_pkg;

  localparam int WORD_W    = 128;
  localparam int NUM_WORDS = 5;
  localparam int STATE_W   = WORD_W * NUM_WORDS;
  localparam int BYTES     = WORD_W / 8;
  localparam int COLS      = 4;
  localparam int ROWS      = 4;

  typedef struct packed {
    logic doLoad;
    logic doStep;
  } stepCtl_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = xtime(x);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  // multiplicative inverse as a^254, then the affine map
  function automatic logic [7:0] sboxByte(input logic [7:0] a);
    logic [7:0] pw;
    logic [7:0] inv;
    pw  = a;
    inv = 8'h01;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) inv = gfMul(inv, pw);
      pw = gfMul(pw, pw);
    end
    return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
  endfunction

endpackage

// File: rtl/aes_round_lane.sv
module aes_round_lane
  import aegis_step_pkg::*;
(
  input  logic [WORD_W-1:0] roundIn,
  input  logic [WORD_W-1:0] roundKey,
  output logic [WORD_W-1:0] roundOut
);

  logic [WORD_W-1:0] subbed;
  logic [WORD_W-1:0] shifted;
  logic [WORD_W-1:0] mixed;

  for (genvar k = 0; k < BYTES; k++) begin : g_sub
    assign subbed[8*k +: 8] = sboxByte(roundIn[8*k +: 8]);
  end

  // row r of column c takes the byte from column c+r
  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign shifted[8*(c*ROWS+r) +: 8] = subbed[8*((((c+r)%COLS)*ROWS)+r) +: 8];
    end

    logic [7:0] a0, a1, a2, a3;
    assign a0 = shifted[8*(c*ROWS+0) +: 8];
    assign a1 = shifted[8*(c*ROWS+1) +: 8];
    assign a2 = shifted[8*(c*ROWS+2) +: 8];
    assign a3 = shifted[8*(c*ROWS+3) +: 8];

    assign mixed[8*(c*ROWS+0) +: 8] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
    assign mixed[8*(c*ROWS+1) +: 8] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
    assign mixed[8*(c*ROWS+2) +: 8] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
    assign mixed[8*(c*ROWS+3) +: 8] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
  end

  assign roundOut = mixed ^ roundKey;

endmodule

// File: rtl/aegis_step_ctrl.sv
module aegis_step_ctrl
  import aegis_step_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     loadEn,
  input  logic     stepEn,
  output stepCtl_t ctl
);

  always_comb begin
    ctl.doLoad = loadEn;
    ctl.doStep = stepEn && !loadEn;
  end

  // R3: a load request never lets a step through
  p_prio_r3: assert property (@(posedge clk) disable iff (rst)
    loadEn |-> (ctl.doLoad && !ctl.doStep));

  // R9: a lone step request always reaches the datapath
  p_step_pass_r9: assert property (@(posedge clk) disable iff (rst)
    (stepEn && !loadEn) |-> ctl.doStep);

endmodule

// File: rtl/aegis_step_datapath.sv
module aegis_step_datapath
  import aegis_step_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  stepCtl_t           ctl,
  input  logic [STATE_W-1:0] loadState,
  input  logic [WORD_W-1:0]  msgWord,
  output logic [STATE_W-1:0] stateOut,
  output logic [WORD_W-1:0]  keyStream
);

  logic [WORD_W-1:0] word     [NUM_WORDS];
  logic [WORD_W-1:0] rndOut   [NUM_WORDS];
  logic [WORD_W-1:0] stepWord [NUM_WORDS];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_lane
    aes_round_lane u_lane (
      .roundIn  (word[(i + NUM_WORDS - 1) % NUM_WORDS]),
      .roundKey (word[i]),
      .roundOut (rndOut[i])
    );
    if (i == 0) begin : g_absorb
      assign stepWord[i] = rndOut[i] ^ msgWord;
    end else begin : g_plain
      assign stepWord[i] = rndOut[i];
    end
    assign stateOut[WORD_W*i +: WORD_W] = word[i];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (rst)             word[i] <= '0;
      else if (ctl.doLoad) word[i] <= loadState[WORD_W*i +: WORD_W];
      else if (ctl.doStep) word[i] <= stepWord[i];
    end
  end

  assign keyStream = word[1] ^ word[4] ^ (word[2] & word[3]);

  // R1: the cycle after reset the state is clear
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (stateOut == '0));

  // R2: a load lands whole on the next edge
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    ctl.doLoad |=> (stateOut == $past(loadState)));

  // R4: without a strobe the state does not move
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctl.doLoad && !ctl.doStep) |=> $stable(stateOut));

  // R8: known answer from the all-zero state
  p_zero_kat_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl.doStep && !ctl.doLoad && stateOut == '0 && msgWord == '0)
      |=> (stateOut == {(NUM_WORDS*BYTES){8'h63}}));

endmodule

// File: rtl/aegis_step_unit.sv
module aegis_step_unit
  import aegis_step_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               loadEn,
  input  logic [STATE_W-1:0] loadState,
  input  logic               stepEn,
  input  logic [WORD_W-1:0]  msgWord,
  output logic [STATE_W-1:0] stateOut,
  output logic [WORD_W-1:0]  keyStream
);

  stepCtl_t ctl;

  aegis_step_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .loadEn (loadEn),
    .stepEn (stepEn),
    .ctl    (ctl)
  );

  aegis_step_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .loadState (loadState),
    .msgWord   (msgWord),
    .stateOut  (stateOut),
    .keyStream (keyStream)
  );

endmodule

// File: tb/aegis_step_unit_tb.sv
module aegis_step_unit_tb;

  logic         clk = 1'b0;
  logic         rst;
  logic         loadEn;
  logic [639:0] loadState;
  logic         stepEn;
  logic [127:0] msgWord;
  logic [639:0] stateOut;
  logic [127:0] keyStream;

  int checks = 0;
  int fails  = 0;

  logic [7:0]   sboxTab [256];
  logic [127:0] mdl     [5];

  always #5 clk = ~clk;

  aegis_step_unit u_dut (
    .clk       (clk),
    .rst       (rst),
    .loadEn    (loadEn),
    .loadState (loadState),
    .stepEn    (stepEn),
    .msgWord   (msgWord),
    .stateOut  (stateOut),
    .keyStream (keyStream)
  );

  function automatic int mulInt(int a, int b);
    int p = 0;
    for (int i = 0; i < 8; i++) begin
      if (((b >> i) & 1) == 1) p = p ^ a;
      a = a << 1;
      if ((a & 256) != 0) a = a ^ 283;
    end
    return p & 255;
  endfunction

  function automatic int xt(int b);
    return ((b << 1) ^ (((b & 128) != 0) ? 27 : 0)) & 255;
  endfunction

  task automatic buildSbox();
    for (int x = 0; x < 256; x++) begin
      int inv = 0;
      int res = 0;
      for (int y = 1; y < 256; y++) if (mulInt(x, y) == 1) inv = y;
      for (int i = 0; i < 8; i++) begin
        int bitv = (inv >> i) ^ (inv >> ((i + 4) % 8)) ^ (inv >> ((i + 5) % 8))
                 ^ (inv >> ((i + 6) % 8)) ^ (inv >> ((i + 7) % 8)) ^ (8'h63 >> i);
        res = res | ((bitv & 1) << i);
      end
      sboxTab[x] = 8'(res);
    end
  endtask

  function automatic logic [127:0] refRound(logic [127:0] x, logic [127:0] key);
    int sb [16];
    int sh [16];
    logic [127:0] o;
    for (int k = 0; k < 16; k++) sb[k] = int'(sboxTab[x[8*k +: 8]]);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) sh[c*4 + r] = sb[((c + r) % 4) * 4 + r];
    for (int c = 0; c < 4; c++) begin
      int a0 = sh[c*4], a1 = sh[c*4+1], a2 = sh[c*4+2], a3 = sh[c*4+3];
      o[8*(c*4)   +: 8] = 8'(xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3);
      o[8*(c*4+1) +: 8] = 8'(a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3);
      o[8*(c*4+2) +: 8] = 8'(a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3);
      o[8*(c*4+3) +: 8] = 8'(xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3));
    end
    return o ^ key;
  endfunction

  function automatic logic [127:0] mk(int n);
    return {32'(n * 32'h9E3779B9), 32'(n * 32'h85EBCA6B + 1),
            32'(n * 32'hC2B2AE35 + 7), 32'(n) ^ 32'h5BD1E995};
  endfunction

  function automatic logic [639:0] packMdl();
    logic [639:0] p;
    for (int i = 0; i < 5; i++) p[128*i +: 128] = mdl[i];
    return p;
  endfunction

  task automatic check640(string tag, logic [639:0] act, logic [639:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s state actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check128(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s word actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic cycle(logic r, logic ld, logic st, logic [127:0] m,
                       logic [639:0] lv, string tag);
    logic [127:0] nxt [5];
    rst = r; loadEn = ld; stepEn = st; msgWord = m; loadState = lv;
    for (int i = 0; i < 5; i++) begin
      if (r)       nxt[i] = '0;
      else if (ld) nxt[i] = lv[128*i +: 128];
      else if (st) nxt[i] = refRound(mdl[(i + 4) % 5], mdl[i]) ^ ((i == 0) ? m : 128'h0);
      else         nxt[i] = mdl[i];
    end
    @(posedge clk);
    for (int i = 0; i < 5; i++) mdl[i] = nxt[i];
    @(negedge clk);
    check640(tag, stateOut, packMdl());
    check128("R7", keyStream, mdl[1] ^ mdl[4] ^ (mdl[2] & mdl[3]));
  endtask

  function automatic logic [639:0] mkState(int base);
    logic [639:0] s;
    for (int i = 0; i < 5; i++) s[128*i +: 128] = mk(base + i);
    return s;
  endfunction

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    rst = 1'b1; loadEn = 1'b0; stepEn = 1'b0; msgWord = '0; loadState = '0;
    for (int i = 0; i < 5; i++) mdl[i] = '0;
    buildSbox();
    @(negedge clk);

    // R1: reset state
    cycle(1, 0, 0, '0, '0, "R1");
    cycle(1, 0, 1, mk(3), mkState(50), "R1");
    check128("R1", keyStream, 128'h0);

    // R8: known answer from zero with zero message
    cycle(0, 0, 1, '0, '0, "R5");
    check640("R8", stateOut, {80{8'h63}});

    // R6: message absorbed into word 0
    cycle(0, 0, 1, mk(1), '0, "R6");

    // R2: parallel load
    cycle(0, 1, 0, mk(9), mkState(10), "R2");
    check128("R2", stateOut[128*3 +: 128], mk(13));

    // R4: idle cycles ignore a nonzero message
    for (int n = 0; n < 3; n++) cycle(0, 0, 0, mk(70 + n), '0, "R4");
    check640("R4", stateOut, mkState(10));

    // R3: load and step together, load wins
    cycle(0, 1, 1, mk(5), mkState(30), "R3");
    check640("R3", stateOut, mkState(30));

    // R5 R6 R9: back-to-back steps with varied messages
    for (int n = 0; n < 8; n++) cycle(0, 0, 1, (n % 3 == 0) ? 128'h0 : mk(20 + n), '0, "R9");

    // R5: steps from a loaded pattern with zero message
    cycle(0, 1, 0, '0, mkState(40), "R2");
    cycle(0, 0, 1, '0, '0, "R5");
    cycle(0, 0, 1, '0, '0, "R5");

    // R1: reset mid-run, then R8 again
    cycle(1, 0, 1, mk(2), '0, "R1");
    cycle(0, 0, 1, '0, '0, "R8");
    check640("R8", stateOut, {80{8'h63}});
    cycle(0, 0, 0, mk(99), '0, "R4");

    finishRun();
  end

endmodule